// File: doc/BRIEF.md
# Variable-Period PWM with Averaged Current Sensing

This block produces the gate drive of a switching power stage whose switching period and on-time may both change from one cycle to the next. A period counter drives a three-state sequencer. The sequencer holds the gate high for the first part of each period and low for the rest. It takes a new period, on-time, burst flag and trigger spacing only at the boundary between two periods. The effect of a command therefore starts with the next complete cycle. Commands that would yield a degenerate waveform are bounded: a period shorter than two clocks is stretched to two, and an on-time that would fill the whole period is cut back so that one clock of off-time remains.

Alongside the modulator, a trigger generator asks an external converter for a conversion at a fixed spacing. The spacing is counted from the start of every period. An averager sums every valid sample that arrives during the period. One clock after the last clock of the period, it presents the sum divided by the number of samples taken and pulses a valid strobe, then starts again from zero. Oversampling in this way lowers the effect of switching noise on the current reading, which matters most at light load.

The sequencer has three states. ST_LOAD is entered by reset and lasts one clock; it loads the first command and moves to ST_ON when the bounded on-time is non-zero, or to ST_OFF otherwise. ST_ON moves to ST_OFF after its last on clock. ST_OFF stays put until the last clock of the period. At the last clock of the period, both ST_ON and ST_OFF reload the command and move to ST_ON or ST_OFF by the same rule as ST_LOAD.

Top module: `vp_dpwm_top`

## Requirements
- R1: While reset is asserted, gate_o, eop_o, trig_o and avg_vld_o are 0 and avg_o is 0.
- R2: eop_o is high for exactly one clock at the end of each period, and a period lasts max(period_i, 2) clocks.
- R3: With burst enabled, gate_o is high during the first N clocks of each period and low for the rest, where N is the bounded on-time.
- R4: An on-time of 0 keeps gate_o low for the whole period.
- R5: An on-time equal to or greater than the effective period P gives P-1 high clocks, so gate_o is always low while eop_o is high.
- R6: period_i, ontime_i, burst_en_i and trig_div_i are sampled only on the clock edge that ends a period (the edge at which eop_o is high) and on the first edge after reset. A change during a period has no effect until the next period.
- R7: With burst_en_i at 0, gate_o stays low for the whole period, while eop_o and trig_o follow the same timing as with burst enabled.
- R8: trig_o pulses on period clocks 0, D, 2D and so on, numbering the first clock of the period 0, which gives ceil(P/D) pulses per period. D is max(trig_div_i, 1), and the spacing restarts at every period.
- R9: One clock after eop_o, avg_vld_o is high for one clock. At the same time avg_o holds floor(S/C), where S is the sum and C the count of samples with adc_valid_i high during that period, including its last clock. avg_o is 0 when C is 0.
- R10: At most 255 samples are counted per period. Further samples in the same period are ignored.
- R11: The sum and count restart at zero every period, so each average depends only on the samples of its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| period_i | input | 16 | Requested period length in clocks |
| ontime_i | input | 16 | Requested gate on-time in clocks |
| burst_en_i | input | 1 | 1 lets the gate switch, 0 holds it low |
| trig_div_i | input | 8 | Clocks between conversion triggers |
| adc_valid_i | input | 1 | A sample is present on adc_data_i |
| adc_data_i | input | 12 | Unsigned current sample |
| gate_o | output | 1 | Gate drive |
| eop_o | output | 1 | High on the last clock of each period |
| trig_o | output | 1 | Conversion request |
| avg_o | output | 12 | Average of the last completed period |
| avg_vld_o | output | 1 | avg_o has just been updated |

## Verification
Two effects are hard to see at the ports: a command that changes in the middle of a period, and a count that reaches its limit. The bench changes the command partway through a measured period and confirms that the period in progress keeps its old length and on-time while the next one follows the new values. To reach the count limit it runs a 300-clock period with a sample on every clock. The samples after the 255th carry a very different value, so any of them that slipped into the sum would move the average visibly.

// File: rtl/vp_dpwm_pkg.sv
package vp_dpwm_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } pwm_state_e;

    localparam int unsigned MIN_PERIOD = 2;
    localparam int unsigned MIN_DIV    = 1;
endpackage

// File: rtl/vp_dpwm_timer.sv
module vp_dpwm_timer
    import vp_dpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] ontime_i,
    input  logic             burst_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             gate_o,
    output logic             eop_o,
    output logic             run_o,
    output logic [DIV_W-1:0] div_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] MINP = CNT_W'(MIN_PERIOD);
    localparam logic [DIV_W-1:0] MIND = DIV_W'(MIN_DIV);

    pwm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, per_q, on_q;
    logic [CNT_W-1:0] per_eff, on_eff;
    logic [DIV_W-1:0] div_q, div_eff;
    logic             burst_q;
    logic             wrap, load;

    // bounding of the incoming command
    always_comb begin
        per_eff = (period_i < MINP) ? MINP : period_i;
        on_eff  = (ontime_i >= per_eff) ? (per_eff - ONE) : ontime_i;
        div_eff = (div_i < MIND) ? MIND : div_i;
    end

    assign wrap = (state_q != ST_LOAD) && (cnt_q == per_q - ONE);
    assign load = (state_q == ST_LOAD) || wrap;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = (on_eff != '0) ? ST_ON : ST_OFF;
            ST_ON: begin
                if (wrap)                    state_d = (on_eff != '0) ? ST_ON : ST_OFF;
                else if (cnt_q == on_q - ONE) state_d = ST_OFF;
                else                         state_d = ST_ON;
            end
            ST_OFF: begin
                if (wrap) state_d = (on_eff != '0) ? ST_ON : ST_OFF;
                else      state_d = ST_OFF;
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // state register and period-boundary buffers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
            per_q   <= MINP;
            on_q    <= '0;
            burst_q <= 1'b0;
            div_q   <= MIND;
        end else begin
            state_q <= state_d;
            if (load) begin
                cnt_q   <= '0;
                per_q   <= per_eff;
                on_q    <= on_eff;
                burst_q <= burst_i;
                div_q   <= div_eff;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // outputs
    always_comb begin
        gate_o = (state_q == ST_ON) && burst_q;
        eop_o  = wrap;
        run_o  = (state_q != ST_LOAD);
        div_o  = div_q;
    end

    assert_gate_low_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_o |-> !gate_o);

    assert_burst_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !burst_q |-> !gate_o);

    assert_zero_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && on_q == '0) |-> !gate_o);

    assert_hold_midperiod_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_q) != ST_LOAD && !$past(wrap)) |-> ($stable(per_q) && $stable(on_q)));
endmodule

// File: rtl/vp_dpwm_trig.sv
module vp_dpwm_trig #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             eop_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             trig_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] tcnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tcnt_q <= '0;
        end else if (!run_i || eop_i) begin
            tcnt_q <= '0;
        end else if (tcnt_q == div_i - ONE) begin
            tcnt_q <= '0;
        end else begin
            tcnt_q <= tcnt_q + ONE;
        end
    end

    assign trig_o = run_i && (tcnt_q == '0);

    assert_trig_at_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(eop_i) |-> trig_o);
endmodule

// File: rtl/vp_dpwm_avg.sv
module vp_dpwm_avg #(
    parameter int unsigned SMP_W  = 12,
    parameter int unsigned SCNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             eop_i,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] data_i,
    output logic [SMP_W-1:0] avg_o,
    output logic             avg_vld_o
);
    localparam int unsigned ACC_W = SMP_W + SCNT_W;
    localparam logic [SCNT_W-1:0] CNT_MAX = {SCNT_W{1'b1}};

    logic [ACC_W-1:0]  sum_q, sum_n;
    logic [SCNT_W-1:0] n_q, n_n;
    logic [SMP_W-1:0]  avg_q;
    logic              vld_q, take;

    always_comb begin
        take  = vld_i && (n_q != CNT_MAX);
        sum_n = sum_q + (take ? ACC_W'(data_i) : '0);
        n_n   = n_q + SCNT_W'(take);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sum_q <= '0;
            n_q   <= '0;
            avg_q <= '0;
            vld_q <= 1'b0;
        end else if (eop_i) begin
            avg_q <= (n_n == '0) ? '0 : SMP_W'(sum_n / ACC_W'(n_n));
            vld_q <= 1'b1;
            sum_q <= '0;
            n_q   <= '0;
        end else begin
            sum_q <= sum_n;
            n_q   <= n_n;
            vld_q <= 1'b0;
        end
    end

    assign avg_o     = avg_q;
    assign avg_vld_o = vld_q;

    assert_vld_follows_eop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |-> (avg_vld_o == $past(eop_i)));

    assert_count_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (n_q == CNT_MAX && !eop_i) |=> (n_q == CNT_MAX));

    assert_clear_after_eop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_i |=> (n_q == '0 && sum_q == '0));
endmodule

// File: rtl/vp_dpwm_top.sv
module vp_dpwm_top #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned SMP_W  = 12,
    parameter int unsigned SCNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] ontime_i,
    input  logic             burst_en_i,
    input  logic [DIV_W-1:0] trig_div_i,
    input  logic             adc_valid_i,
    input  logic [SMP_W-1:0] adc_data_i,
    output logic             gate_o,
    output logic             eop_o,
    output logic             trig_o,
    output logic [SMP_W-1:0] avg_o,
    output logic             avg_vld_o
);
    logic             run;
    logic [DIV_W-1:0] div_act;

    vp_dpwm_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .period_i (period_i),
        .ontime_i (ontime_i),
        .burst_i  (burst_en_i),
        .div_i    (trig_div_i),
        .gate_o   (gate_o),
        .eop_o    (eop_o),
        .run_o    (run),
        .div_o    (div_act)
    );

    vp_dpwm_trig #(.DIV_W(DIV_W)) trig_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .eop_i  (eop_o),
        .div_i  (div_act),
        .trig_o (trig_o)
    );

    vp_dpwm_avg #(.SMP_W(SMP_W), .SCNT_W(SCNT_W)) avg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .eop_i     (eop_o),
        .vld_i     (adc_valid_i),
        .data_i    (adc_data_i),
        .avg_o     (avg_o),
        .avg_vld_o (avg_vld_o)
    );

    assert_single_eop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_o |=> !eop_o);
endmodule

// File: tb/vp_dpwm_top_tb_top.sv
module vp_dpwm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period = 16'd20;
    logic [15:0] ontime = 16'd5;
    logic        burst = 1'b1;
    logic [7:0]  tdiv = 8'd4;
    logic        adc_vld = 1'b0;
    logic [11:0] adc_dat = '0;
    logic        gate, eop, trig, avg_vld;
    logic [11:0] avg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vp_dpwm_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .period_i    (period),
        .ontime_i    (ontime),
        .burst_en_i  (burst),
        .trig_div_i  (tdiv),
        .adc_valid_i (adc_vld),
        .adc_data_i  (adc_dat),
        .gate_o      (gate),
        .eop_o       (eop),
        .trig_o      (trig),
        .avg_o       (avg),
        .avg_vld_o   (avg_vld)
    );

    // period, ontime, burst, div, exp_len, exp_high, exp_trigs
    localparam int NV = 8;
    localparam int VEC [NV][7] = '{
        '{20,   5, 1,  4, 20,  5,  5},   // R3 R8
        '{10,   0, 1,  3, 10,  0,  4},   // R4
        '{ 8,   8, 1,  0,  8,  7,  8},   // R5 R8 div zero
        '{ 8, 100, 1,  2,  8,  7,  4},   // R5
        '{ 1,   1, 1,  1,  2,  1,  2},   // R2 minimum period
        '{30,  12, 0,  7, 30,  0,  5},   // R7
        '{ 0,   0, 1,  5,  2,  0,  1},   // R2 R4
        '{50,  49, 1, 50, 50, 49,  1}    // R3 R5
    };

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_eop();
        do @(negedge clk); while (!eop);
    endtask

    task automatic measure(output int len, output int hi, output int tr);
        len = 0; hi = 0; tr = 0;
        do begin
            @(negedge clk);
            len++;
            hi += int'(gate);
            tr += int'(trig);
        end while (!eop);
    endtask

    // drive one period of samples; mode picks the pattern
    task automatic avg_run(input string rq, input int p, input int mode);
        int sum = 0;
        int cnt = 0;
        int expv;
        @(negedge clk);
        period = 16'(p); ontime = 16'd1; burst = 1'b1; tdiv = 8'd1;
        wait_eop();
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            case (mode)
                0: begin adc_vld = 1'b1; adc_dat = 12'(100 + 3 * i); end
                1: begin adc_vld = (i % 2 == 0); adc_dat = 12'(50 * i); end
                2: begin adc_vld = 1'b0; adc_dat = 12'hFFF; end
                default: begin adc_vld = 1'b1; adc_dat = (i < 255) ? 12'd10 : 12'd4000; end
            endcase
            if (adc_vld && cnt < 255) begin
                sum += int'(adc_dat);
                cnt++;
            end
        end
        chk({rq, " eop at last sample clock"}, int'(eop), 1);
        @(negedge clk);
        adc_vld = 1'b0;
        expv = (cnt == 0) ? 0 : sum / cnt;
        chk({rq, " avg valid"}, int'(avg_vld), 1);
        chk({rq, " avg value"}, int'(avg), expv);
        @(negedge clk);
        chk({rq, " avg valid one clock"}, int'(avg_vld), 0);
    endtask

    initial begin
        int len, hi, tr;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 gate", int'(gate), 0);
        chk("R1 eop", int'(eop), 0);
        chk("R1 trig", int'(trig), 0);
        chk("R1 avg_vld", int'(avg_vld), 0);
        chk("R1 avg", int'(avg), 0);
        rst_n = 1'b1;

        // vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            period = 16'(VEC[v][0]);
            ontime = 16'(VEC[v][1]);
            burst  = VEC[v][2][0];
            tdiv   = 8'(VEC[v][3]);
            wait_eop();
            measure(len, hi, tr);
            chk($sformatf("R2 period len vec %0d", v), len, VEC[v][4]);
            chk($sformatf("R3 R4 R5 R7 high clocks vec %0d", v), hi, VEC[v][5]);
            chk($sformatf("R8 trigger count vec %0d", v), tr, VEC[v][6]);
        end

        // R6: mid-period command change
        @(negedge clk);
        period = 16'd20; ontime = 16'd5; burst = 1'b1; tdiv = 8'd4;
        wait_eop();
        len = 0; hi = 0;
        do begin
            @(negedge clk);
            len++;
            hi += int'(gate);
            if (len == 7) begin
                period = 16'd12; ontime = 16'd3; tdiv = 8'd6;
            end
        end while (!eop);
        chk("R6 current period kept length", len, 20);
        chk("R6 current period kept on-time", hi, 5);
        measure(len, hi, tr);
        chk("R6 next period length", len, 12);
        chk("R6 next period on-time", hi, 3);
        chk("R6 R8 next period triggers", tr, 2);

        // averaging
        avg_run("R9 all valid", 16, 0);
        avg_run("R9 R11 even samples", 16, 1);
        avg_run("R9 no samples", 10, 2);
        avg_run("R10 count cap", 300, 3);
        avg_run("R11 fresh after cap", 16, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule